// File: doc/BRIEF.md
# Multi-Channel Compare Capture Timer

This block is a timer/counter with four compare/capture channels, driven through a simple 32-bit register port. In timer mode the counter advances on a tick made by dividing the block clock by a power of two. In counter mode it advances by one each time software fires a count task. Software starts, stops, clears and captures the counter by writing a trigger value to task addresses.

Each channel holds a compare value. When the counter steps onto that value, the channel's event flag is set and stays set until software clears it. Per-channel shortcut bits can make a match reset the counter to zero or halt the timer. One interrupt line combines the event flags with a per-channel enable mask. The enable mask has separate set and clear addresses.

The counter width is chosen at run time from four encodings, and the counter wraps at that width. Reads are combinational from the addressed register. Writes take effect at the clock edge that samples them.

Top module: `ccap_timer`

## Requirements
- R1: After reset the counter is 0 and stopped; every readable register (events, shortcuts, enables, mode, width, prescaler, compare values) reads 0 and `irq` is low.
- R2: Word addresses: start 0x00, stop 0x01, count 0x02, clear 0x03, shutdown 0x04, capture i 0x08+i, event i 0x10+i, shortcuts 0x20, enable-set 0x21, enable-clear 0x22, mode 0x23, width 0x24, prescaler 0x25, compare i 0x28+i. A task fires only on a write of exactly 1, and any other value has no effect. The shortcut register keeps only bits 3:0 and 11:8.
- R3: With mode 0 (timer) and prescaler P, a start task makes the counter advance once every 2^P clock cycles. A stop task or a shutdown task halts it. A start task written in mode 1 is ignored.
- R4: With mode 1 (counter), each count task adds one to the counter. In mode 0 a count task is ignored.
- R5: The width code selects the counter width: 0 gives 16 bits, 1 gives 8, 2 gives 24 and 3 gives 32. The counter wraps to 0 modulo 2^width.
- R6: A value written to compare i is stored reduced modulo 2^width and reads back as stored.
- R7: A capture i task copies the current counter value into compare i.
- R8: The increment that brings the counter equal to compare i sets event i, which reads 1 until a write of 0 to event i. A write of any nonzero value to event i leaves it set.
- R9: With shortcut bit i set, a match on channel i loads the counter with 0 instead of the matching value.
- R10: With shortcut bit 8+i set, a match on channel i halts the timer, and the counter holds the matching value.
- R11: `irq` is high exactly when some event i is set while enable bit 16+i is set. Writing 1s to enable-set sets those bits, and writing 1s to enable-clear clears them. Both addresses read the enable value, which contains only bits 19:16.
- R12: A clear task sets the counter to 0 and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the undivided tick source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one register access |
| reg_addr | input | 6 | Word address for a read or a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: four channels, a 4-bit prescaler and a 16-bit divider. At these values every width code and every channel address can be reached directly. The bench sweeps prescaler values 0 to 3 against several run lengths, so each elapsed count is an integer shift of the number of cycles. An 8-bit width lets a few hundred count tasks wrap the counter. Masking on compare writes is checked for every width code, which covers the 16-, 24- and 32-bit wraps without counting through them.

// File: rtl/ccap_pkg.sv
package ccap_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] ADR_START = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_STOP  = 6'h01;
  localparam logic [ADDR_W-1:0] ADR_COUNT = 6'h02;
  localparam logic [ADDR_W-1:0] ADR_CLEAR = 6'h03;
  localparam logic [ADDR_W-1:0] ADR_SHUT  = 6'h04;
  localparam logic [ADDR_W-1:0] ADR_CAP0  = 6'h08;
  localparam logic [ADDR_W-1:0] ADR_EV0   = 6'h10;
  localparam logic [ADDR_W-1:0] ADR_SHORT = 6'h20;
  localparam logic [ADDR_W-1:0] ADR_IESET = 6'h21;
  localparam logic [ADDR_W-1:0] ADR_IECLR = 6'h22;
  localparam logic [ADDR_W-1:0] ADR_MODE  = 6'h23;
  localparam logic [ADDR_W-1:0] ADR_WIDTH = 6'h24;
  localparam logic [ADDR_W-1:0] ADR_PSC   = 6'h25;
  localparam logic [ADDR_W-1:0] ADR_CMP0  = 6'h28;

  localparam int STOP_SC_LSB = 8;
  localparam int IEN_LSB     = 16;

  typedef enum logic {MODE_TIMER = 1'b0, MODE_COUNTER = 1'b1} tmode_e;

  // Width code to wrap mask; the codes are not in size order.
  function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] code);
    logic [DATA_W-1:0] m;
    case (code)
      2'd0:    m = 32'h0000_FFFF;
      2'd1:    m = 32'h0000_00FF;
      2'd2:    m = 32'h00FF_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ccap_prescaler.sv
module ccap_prescaler #(
  parameter int PSC_W = 4,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [DIV_W-1:0] div_q, div_d, sel_mask;

  always_comb begin
    sel_mask = (DIV_W'(1) << psc) - DIV_W'(1);
    tick     = run && ((div_q & sel_mask) == sel_mask);
    if (!run || restart) div_d = '0;
    else                 div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R3: with a divider above 1, two ticks never come back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psc != '0) |=> (!tick || psc != $past(psc)));
endmodule

// File: rtl/ccap_counter.sv
module ccap_counter #(
  parameter int CNT_W = 32,
  parameter int NCH   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inc,
  input  logic                      clr,
  input  logic [CNT_W-1:0]          wmask,
  input  logic [NCH-1:0][CNT_W-1:0] cmp,
  input  logic [NCH-1:0]            short_clr,
  output logic [CNT_W-1:0]          cnt,
  output logic [NCH-1:0]            match
);
  logic [CNT_W-1:0] nxt, cnt_d;
  logic             cnt_en;

  always_comb begin
    nxt = (cnt + CNT_W'(1)) & wmask;
    for (int i = 0; i < NCH; i++)
      match[i] = inc && !clr && (nxt == cmp[i]);
    cnt_en = inc || clr;
    if (clr)                        cnt_d = '0;
    else if (|(match & short_clr))  cnt_d = '0;
    else                            cnt_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  a_r12_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  a_r9_short_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (|(match & short_clr)) |=> cnt == '0);
  a_r5_wrap_range: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt & ~$past(wmask)) == '0);
endmodule

// File: rtl/ccap_channel.sv
module ccap_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] wmask,
  input  logic             cap,
  input  logic [CNT_W-1:0] cnt,
  input  logic             match,
  input  logic             ev_clr,
  output logic [CNT_W-1:0] cmp,
  output logic             ev
);
  logic [CNT_W-1:0] cmp_d;
  logic             cmp_en, ev_d;

  always_comb begin
    cmp_en = cmp_wr || cap;
    cmp_d  = cap ? cnt : (wdata & wmask);
    if (match)       ev_d = 1'b1;
    else if (ev_clr) ev_d = 1'b0;
    else             ev_d = ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= '0;
      ev  <= 1'b0;
    end else begin
      if (cmp_en) cmp <= cmp_d;
      ev <= ev_d;
    end
  end

  a_r8_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !ev_clr) |=> ev);
  a_r6_cmp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> (cmp & ~$past(wmask)) == '0);
  a_r7_capture_copy: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> cmp == $past(cnt));
endmodule

// File: rtl/ccap_timer.sv
module ccap_timer
  import ccap_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int PSC_W = 4,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CNT_W = DATA_W;

  logic trig;
  logic start_t, stop_t, count_t, clr_t, shut_t;
  logic [NCH-1:0] cap_t, ev_clr, cmp_wr, match, ev;
  logic [NCH-1:0][CNT_W-1:0] cmp;
  logic [CNT_W-1:0] cnt, wmask;
  logic tick, inc, run_gate;

  tmode_e         mode_q, mode_d;
  logic [1:0]     wsel_q, wsel_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [NCH-1:0] sc_clr_q, sc_clr_d, sc_stop_q, sc_stop_d, ien_q, ien_d;
  logic           run_q, run_d;
  logic           mode_en, wsel_en, psc_en, sc_en, ien_en;

  // Task and write decode
  always_comb begin
    trig    = (reg_wdata == DATA_W'(1));
    start_t = reg_wr && trig && reg_addr == ADR_START;
    stop_t  = reg_wr && trig && reg_addr == ADR_STOP;
    count_t = reg_wr && trig && reg_addr == ADR_COUNT;
    clr_t   = reg_wr && trig && reg_addr == ADR_CLEAR;
    shut_t  = reg_wr && trig && reg_addr == ADR_SHUT;
    mode_en = reg_wr && reg_addr == ADR_MODE;
    wsel_en = reg_wr && reg_addr == ADR_WIDTH;
    psc_en  = reg_wr && reg_addr == ADR_PSC;
    sc_en   = reg_wr && reg_addr == ADR_SHORT;
    ien_en  = reg_wr && (reg_addr == ADR_IESET || reg_addr == ADR_IECLR);
  end

  // Control register next state
  always_comb begin
    mode_d    = tmode_e'(reg_wdata[0]);
    wsel_d    = reg_wdata[1:0];
    psc_d     = reg_wdata[PSC_W-1:0];
    sc_clr_d  = reg_wdata[NCH-1:0];
    sc_stop_d = reg_wdata[STOP_SC_LSB +: NCH];
    if (reg_addr == ADR_IESET) ien_d = ien_q | reg_wdata[IEN_LSB +: NCH];
    else                       ien_d = ien_q & ~reg_wdata[IEN_LSB +: NCH];
    if (start_t && mode_q == MODE_TIMER)                 run_d = 1'b1;
    else if (stop_t || shut_t || (|(match & sc_stop_q))) run_d = 1'b0;
    else                                                 run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_TIMER;
      wsel_q    <= '0;
      psc_q     <= '0;
      sc_clr_q  <= '0;
      sc_stop_q <= '0;
      ien_q     <= '0;
      run_q     <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (wsel_en) wsel_q <= wsel_d;
      if (psc_en)  psc_q  <= psc_d;
      if (sc_en) begin
        sc_clr_q  <= sc_clr_d;
        sc_stop_q <= sc_stop_d;
      end
      if (ien_en)  ien_q  <= ien_d;
      run_q <= run_d;
    end
  end

  always_comb begin
    wmask    = width_mask(wsel_q);
    run_gate = run_q && mode_q == MODE_TIMER;
    inc      = (run_gate && tick) || (mode_q == MODE_COUNTER && count_t);
    irq      = |(ev & ien_q);
  end

  ccap_prescaler #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_gate), .restart(clr_t),
    .psc(psc_q), .tick(tick)
  );

  ccap_counter #(.CNT_W(CNT_W), .NCH(NCH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .clr(clr_t), .wmask(wmask),
    .cmp(cmp), .short_clr(sc_clr_q), .cnt(cnt), .match(match)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cap_t[i]  = reg_wr && trig && reg_addr == ADR_CAP0 + ADDR_W'(i);
    assign ev_clr[i] = reg_wr && reg_wdata == '0 && reg_addr == ADR_EV0 + ADDR_W'(i);
    assign cmp_wr[i] = reg_wr && reg_addr == ADR_CMP0 + ADDR_W'(i);

    ccap_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr[i]), .wdata(reg_wdata),
      .wmask(wmask), .cap(cap_t[i]), .cnt(cnt), .match(match[i]),
      .ev_clr(ev_clr[i]), .cmp(cmp[i]), .ev(ev[i])
    );
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_SHORT: begin
        reg_rdata[NCH-1:0]             = sc_clr_q;
        reg_rdata[STOP_SC_LSB +: NCH]  = sc_stop_q;
      end
      ADR_IESET, ADR_IECLR: reg_rdata[IEN_LSB +: NCH] = ien_q;
      ADR_MODE:  reg_rdata[0]       = mode_q;
      ADR_WIDTH: reg_rdata[1:0]     = wsel_q;
      ADR_PSC:   reg_rdata[PSC_W-1:0] = psc_q;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (reg_addr == ADR_EV0 + ADDR_W'(i))  reg_rdata = DATA_W'(ev[i]);
          if (reg_addr == ADR_CMP0 + ADDR_W'(i)) reg_rdata = cmp[i];
        end
      end
    endcase
  end

  a_r10_stop_short: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(match & sc_stop_q)) && !start_t) |=> !run_q);
  a_r3_halted_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && mode_q == MODE_TIMER && !clr_t) |=> cnt == $past(cnt));
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_COUNTER && count_t && !(|(match & sc_clr_q)))
      |=> cnt == (($past(cnt) + 1) & $past(wmask)));
endmodule

// File: tb/ccap_timer_tb_top.sv
module ccap_timer_tb_top;
  logic        clk, rst_n, reg_wr, irq;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  int errors = 0, checks = 0;
  bit done = 0;

  ccap_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] wm(input int code);
    int w;
    w = (code == 0) ? 16 : (code == 1) ? 8 : (code == 2) ? 24 : 32;
    return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Entered and left at a falling edge.
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_events();
    for (int i = 0; i < 4; i++) wr(6'h10 + 6'(i), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    for (int a = 6'h20; a <= 6'h25; a++) rd("R1 ctrl", 6'(a), 0);
    for (int i = 0; i < 4; i++) begin
      rd("R1 event", 6'h10 + 6'(i), 0);
      rd("R1 compare", 6'h28 + 6'(i), 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);

    // R2: shortcut register keeps only defined bits
    wr(6'h20, 32'hFFFF_FFFF);
    rd("R2 shortcut mask", 6'h20, 32'h0000_0F0F);
    wr(6'h20, 32'h0);

    // R6: compare write reduced per width code
    for (int c = 0; c < 4; c++) begin
      wr(6'h24, c);
      wr(6'h28, 32'hFFFF_FFFF);
      rd("R6 cmp all ones", 6'h28, wm(c));
      wr(6'h29, 32'h1234_5678);
      rd("R6 cmp pattern", 6'h29, 32'h1234_5678 & wm(c));
    end

    // R4/R5: counter mode with 8-bit wrap
    wr(6'h23, 1); wr(6'h24, 1); wr(6'h03, 1);
    for (int k = 0; k < 300; k++) wr(6'h02, 1);
    wr(6'h08, 1);
    rd("R5 8-bit wrap", 6'h28, 300 % 256);
    for (int k = 0; k < 3; k++) wr(6'h02, 2);
    wr(6'h08, 1);
    rd("R2 count value 2 ignored", 6'h28, 300 % 256);

    // R3: timer mode prescaler sweep
    wr(6'h23, 0); wr(6'h24, 3);
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 3; s++) begin
        int n;
        n = (s == 0) ? 0 : (s == 1) ? 5 : 13;
        wr(6'h25, p); wr(6'h03, 1); wr(6'h00, 1);
        idle(n);
        wr(6'h01, 1);
        idle(3);
        wr(6'h09, 1);
        rd("R3 elapsed ticks", 6'h29, (n + 1) >> p);
      end
    end
    // R3: shutdown halts too
    wr(6'h25, 0); wr(6'h03, 1); wr(6'h00, 1);
    idle(7);
    wr(6'h04, 1);
    idle(4);
    wr(6'h09, 1);
    rd("R3 shutdown halts", 6'h29, 8);
    // R3: start ignored in counter mode
    wr(6'h23, 1); wr(6'h03, 1); wr(6'h00, 1);
    idle(10);
    wr(6'h0A, 1);
    rd("R3 start ignored in counter mode", 6'h2A, 0);
    // R4: count ignored in timer mode
    wr(6'h23, 0);
    for (int k = 0; k < 3; k++) wr(6'h02, 1);
    wr(6'h0A, 1);
    rd("R4 count ignored in timer mode", 6'h2A, 0);

    // R12 / R7: clear while running beats the increment
    wr(6'h03, 1); wr(6'h00, 1);
    idle(20);
    wr(6'h03, 1);
    idle(6);
    wr(6'h0B, 1);
    rd("R12 clear priority", 6'h2B, 6);
    wr(6'h01, 1);

    // R8 / R9: counter mode events with clear shortcut
    wr(6'h23, 1); wr(6'h24, 1); wr(6'h03, 1);
    wr(6'h28, 5); wr(6'h29, 200); wr(6'h2A, 201); wr(6'h2B, 202);
    wr(6'h20, 32'h1);
    clear_events();
    for (int k = 0; k < 4; k++) wr(6'h02, 1);
    rd("R8 no event before match", 6'h10, 0);
    wr(6'h02, 1);
    rd("R8 event on match", 6'h10, 1);
    wr(6'h0B, 1);
    rd("R9 short zeroes counter", 6'h2B, 0);
    for (int k = 0; k < 7; k++) wr(6'h02, 1);
    wr(6'h0B, 1);
    rd("R9 second wrap at compare", 6'h2B, 2);
    wr(6'h10, 1);
    rd("R2 nonzero write keeps event", 6'h10, 1);
    wr(6'h10, 0);
    rd("R8 zero write clears event", 6'h10, 0);

    // R10: stop shortcut on channel 2
    wr(6'h23, 0); wr(6'h24, 3); wr(6'h20, 32'h0000_0400);
    wr(6'h2A, 10); wr(6'h2B, 32'h0000_FFFF);
    clear_events();
    wr(6'h03, 1); wr(6'h00, 1);
    idle(30);
    wr(6'h0B, 1);
    rd("R10 held at match value", 6'h2B, 10);
    rd("R10 event2 set", 6'h12, 1);

    // R11: interrupt combine (event0 and event2 set now)
    rd("R11 event0 set", 6'h10, 1);
    chk("R11 irq low without enable", {31'b0, irq}, 0);
    wr(6'h21, 32'h0001_0000);
    chk("R11 irq via enable 16", {31'b0, irq}, 1);
    rd("R11 set reads enable", 6'h21, 32'h0001_0000);
    rd("R11 clear reads enable", 6'h22, 32'h0001_0000);
    wr(6'h22, 32'h0001_0000);
    chk("R11 irq off after enable clear", {31'b0, irq}, 0);
    wr(6'h21, 32'h0004_0000);
    chk("R11 irq via enable 18", {31'b0, irq}, 1);
    wr(6'h12, 0);
    chk("R11 irq off after event clear", {31'b0, irq}, 0);
    wr(6'h21, 32'hFFFF_FFFF);
    rd("R11 enable keeps bits 19:16", 6'h21, 32'h000F_0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule